// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block collects single-cycle event pulses from a network PHY and reduces them to one level-sensitive interrupt line. There are six sources: link status change, jabber, remote fault, auto-negotiation done, false-carrier counter half full and receive-error counter half full. Each source has its own mask bit, and a mask bit of 0 lets that source through. A global enable bit gates all the sources together. Any pulse that passes both the mask and the enable sets a sticky pending flag. The interrupt output follows that flag.

Software uses a small register bus to reach two 16-bit registers: a control register at offset 0xC4 and a status/mask register at offset 0xC8. Reading the status register returns the pending flag and clears it. A test mode makes every bus read raise the interrupt, whatever the global enable is set to. This lets the interrupt path be exercised without a real PHY event.

Top module: `phy_irq_top`

## Requirements
- R1: After reset, both registers read 0x0000 and `irq` is low.
- R2: The control register (0xC4) keeps only bit 1 (event enable) and bit 0 (test mode). Bits 15:2 ignore writes and read 0.
- R3: A write to the status register (0xC8) updates only mask bits 14:9. Bit 15 and bits 8:0 cannot be written, and bits 8:0 always read 0.
- R4: The event pulse on `evt[i]` maps to mask bit 9+i: evt[5] is link, evt[4] jabber, evt[3] remote fault, evt[2] auto-negotiation done, evt[1] false-carrier half full, evt[0] receive-error half full. The pulse sets the pending flag one cycle later only when mask bit 9+i is 0 and the enable bit is 1.
- R5: Once set, the pending flag and `irq` stay high until the status register is read.
- R6: A read of the status register returns the pending flag in bit 15 as it stood before the read. `rd_data` is valid the cycle after `rd_en`. Unless something sets the flag again in the same cycle, the flag and `irq` are low the cycle after the read.
- R7: If an enabled, unmasked event arrives in the same cycle as a status read, the pending flag is set afterwards, so the event is not lost.
- R8: With test mode set, any bus read (to any address) sets the pending flag one cycle later, even when the enable bit is 0. With test mode clear, reads set nothing.
- R9: A read of any other address returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |
| evt | input | 6 | Event pulses, bit mapping as in R4 |
| irq | output | 1 | Interrupt, high while an event is pending |

## Verification
The only state is a six-bit mask, two control bits and the pending flag, and every one of these can be read back over the bus. A corrupted mask or enable bit shows up as a wrong `irq` level in the cycle right after the next event pulse, and also on the next register read. A pending flag that fails to clear or to stick shows up on `irq` within one cycle of the status read or of the event. Sweeping every mask pattern against every source with the enable both on and off covers all the gating combinations.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_EVT  = 6;
  localparam int MASK_LSB = 9;
  localparam int PEND_BIT = 15;
  localparam int EN_BIT   = 1;
  localparam int TEST_BIT = 0;
endpackage

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hC8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              pend,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_en,
  output logic              test_en,
  output logic [NUM_EVT-1:0] mask,
  output logic              stat_rd
);
  logic ctrl_sel, stat_sel;
  logic [REG_W-1:0] rd_mux;

  assign ctrl_sel = (addr == CTRL_ADDR);
  assign stat_sel = (addr == STAT_ADDR);
  assign stat_rd  = rd_en && stat_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en  <= 1'b0;
      test_en <= 1'b0;
      mask    <= '0;
    end else if (wr_en) begin
      if (ctrl_sel) begin
        irq_en  <= wr_data[EN_BIT];
        test_en <= wr_data[TEST_BIT];
      end
      if (stat_sel) mask <= wr_data[MASK_LSB +: NUM_EVT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_sel) begin
      rd_mux[EN_BIT]   = irq_en;
      rd_mux[TEST_BIT] = test_en;
    end else if (stat_sel) begin
      rd_mux[PEND_BIT]                = pend;
      rd_mux[MASK_LSB +: NUM_EVT]     = mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/phy_irq_pending.sv
module phy_irq_pending
  import phy_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] mask,
  input  logic               irq_en,
  input  logic               test_en,
  input  logic               any_rd,
  input  logic               stat_rd,
  output logic               pend
);
  logic [NUM_EVT-1:0] pass;
  logic set_req;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_gate
    assign pass[i] = evt[i] && !mask[i] && irq_en;
  end

  assign set_req = (|pass) || (test_en && any_rd);

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
    else if (stat_rd) pend <= 1'b0;
  end
endmodule

// File: rtl/phy_irq_top.sv
module phy_irq_top
  import phy_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hC8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic [5:0]        evt,
  output logic              irq
);
  logic irq_en, test_en, stat_rd, pend;
  logic [NUM_EVT-1:0] mask_q;

  phy_irq_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .pend(pend), .rd_data(rd_data), .irq_en(irq_en),
    .test_en(test_en), .mask(mask_q), .stat_rd(stat_rd)
  );

  phy_irq_pending u_pend (
    .clk(clk), .rst(rst), .evt(evt), .mask(mask_q), .irq_en(irq_en),
    .test_en(test_en), .any_rd(rd_en), .stat_rd(stat_rd), .pend(pend)
  );

  assign irq = pend;
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hC8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [5:0]        evt,
  input logic [15:0]       rd_data,
  input logic              irq,
  input logic              irq_en,
  input logic              test_en,
  input logic [5:0]        mask_q
);
  logic hit;
  assign hit = irq_en && |(evt & ~mask_q);

  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CTRL_ADDR) |=> (rd_data[15:2] == '0));
  // R3
  stat_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STAT_ADDR) |=> (rd_data[8:0] == '0));
  // R4
  event_raises_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);
  // R5
  pending_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(rd_en && addr == STAT_ADDR)) |=> irq);
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STAT_ADDR && !test_en && !hit) |=> !irq);
  // R6
  read_preclear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STAT_ADDR) |=> (rd_data[15] == $past(irq)));
  // R8
  test_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && test_en) |=> irq);
endmodule

bind phy_irq_top phy_irq_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .evt(evt), .rd_data(rd_data),
  .irq(irq), .irq_en(irq_en), .test_en(test_en), .mask_q(mask_q)
);

// File: tb/tb_phy_irq_top.sv
module tb_phy_irq_top;
  localparam logic [7:0] CTRL = 8'hC4;
  localparam logic [7:0] STAT = 8'hC8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0] evt = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  phy_irq_top dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                   .wr_data(wr_data), .rd_data(rd_data), .evt(evt), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd(CTRL, d); check("R1 ctrl", d, 16'h0000);
    rd(STAT, d); check("R1 stat", d, 16'h0000);
    // R2 control write masking
    wr(CTRL, 16'hFFFC); rd(CTRL, d); check("R2 ctrl", d, 16'h0000);
    wr(CTRL, 16'h0002); rd(CTRL, d); check("R2 ctrl", d, 16'h0002);
    // R3 status write: only mask bits
    wr(STAT, 16'hFFFF); rd(STAT, d); check("R3 stat", d, 16'h7E00);
    check("R3 irq", {15'b0, irq}, 16'h0);
    // R9 unmapped
    rd(8'h10, d); check("R9 unmapped", d, 16'h0000);
    // R4 sweep: every mask, enable on/off, every source
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 64; m++) begin
        wr(CTRL, 16'(en << 1));
        wr(STAT, 16'(m << 9));
        rd(STAT, d);
        for (int i = 0; i < 6; i++) begin
          logic expb;
          expb = (en == 1) && !m[i];
          pulse(6'(1 << i));
          check("R4 irq", {15'b0, irq}, {15'b0, expb});
          rd(STAT, d);
          check("R4 pend", {15'b0, d[15]}, {15'b0, expb});
          check("R4 mask", {1'b0, d[14:0]}, 16'(m << 9));
        end
      end
    end
    // R5 hold, R6 clear on read
    wr(CTRL, 16'h0002); wr(STAT, 16'h0000);
    pulse(6'b100000);
    repeat (5) @(negedge clk);
    check("R5 hold", {15'b0, irq}, 16'h1);
    rd(CTRL, d); check("R5 ctrl read keeps", {15'b0, irq}, 16'h1);
    rd(STAT, d); check("R6 preclear", d, 16'h8000);
    check("R6 irq clear", {15'b0, irq}, 16'h0);
    rd(STAT, d); check("R6 second read", d, 16'h0000);
    // R7 event during status read
    @(negedge clk); addr = STAT; rd_en = 1'b1; evt = 6'b000100;
    @(negedge clk); rd_en = 1'b0; evt = '0;
    check("R7 rd old", rd_data, 16'h0000);
    check("R7 irq", {15'b0, irq}, 16'h1);
    rd(STAT, d); check("R7 pend", d, 16'h8000);
    // R8 test mode, enable off
    wr(CTRL, 16'h0001);
    check("R8 no read yet", {15'b0, irq}, 16'h0);
    pulse(6'b000001);
    check("R8 event gated", {15'b0, irq}, 16'h0);
    rd(CTRL, d); check("R8 ctrl", d, 16'h0001);
    check("R8 irq", {15'b0, irq}, 16'h1);
    rd(STAT, d); check("R8 pend", d[15:9], 7'h40);
    check("R8 reraise", {15'b0, irq}, 16'h1);
    wr(CTRL, 16'h0000);
    rd(STAT, d); check("R8 off clears", {15'b0, irq}, 16'h0);
    rd(8'h20, d); check("R8 no test", {15'b0, irq}, 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule